// File: doc/BRIEF.md
# Four-Word Burst Quad-Rate Static Memory

This block is a synthesizable model of a static memory with a separate read port and write port. The two ports share a single address bus, and every access moves a fixed burst of four full-width words. Each clock cycle carries two data words in parallel lanes: one lane for the rising half and one for the falling half. A four-word burst on either port therefore takes two clock cycles. Reads and writes are requested with active-low port selects. Writes are qualified by active-low byte enables, one for each 9-bit byte of every word.

Storage is split into four sub-arrays, one for each burst position. The address therefore carries no burst-offset bits. A write takes its first two words and their byte enables in the command cycle. In the following cycle it takes its address, its last two words and their byte enables. A read takes its address in the command cycle and presents its words one full cycle later. A valid flag stands in for output three-stating.

Top module: `qdr4_sram`

## Requirements
- R1: A write is accepted when `wr_n` is low at a rising edge and no write burst is in its second cycle. Words 0 and 1 are taken from `din_rise`/`din_fall` in that cycle. The address and words 2 and 3 are taken in the next cycle. While `wr_n` is high, the data, mask and address inputs leave memory unchanged.
- R2: A read is accepted when `rd_n` is low at a rising edge and no earlier read is still waiting for its fetch. The address is sampled at that same edge.
- R3: For a read accepted at edge T, words 0 and 1 appear on `q_rise`/`q_fall` after edge T+1, and words 2 and 3 appear after edge T+2. `q_valid` is high in exactly those two cycles.
- R4: The four words of a burst go to four separate sub-arrays at the same address, and every word is 36 bits wide with the default parameters.
- R5: The byte enables are active low. Bit b of a mask covers data bits 9b+8 down to 9b. The `bw_rise_n` mask qualifies the `din_rise` word of its cycle, and `bw_fall_n` qualifies the `din_fall` word.
- R6: A byte whose enable is high keeps its old contents. Only the enabled bytes of each word change.
- R7: When a read and a write are accepted at the same edge and use the same address, the read returns the data stored before that write.
- R8: A command of the same type in the cycle right after an accepted command is ignored. An ignored write changes no memory, and an ignored read produces no extra valid cycles.
- R9: While `q_valid` is low, `q_rise` and `q_fall` are zero. Reads issued every two cycles keep `q_valid` high without a gap.
- R10: Reset clears every memory location to zero and drives `q_valid` low.
- R11: In the second cycle of a write, the value on the shared address bus is also the read address of a read accepted in that cycle. That read returns the data of the write, which commits at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; every sample is taken at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Read port select, active low |
| wr_n | input | 1 | Write port select, active low |
| addr | input | ADDR_W | Shared address bus |
| din_rise | input | 36 | Write data, rising-half lane |
| din_fall | input | 36 | Write data, falling-half lane |
| bw_rise_n | input | 4 | Active-low byte enables for din_rise |
| bw_fall_n | input | 4 | Active-low byte enables for din_fall |
| q_rise | output | 36 | Read data, rising-half lane |
| q_fall | output | 36 | Read data, falling-half lane |
| q_valid | output | 1 | High while q_rise/q_fall carry burst words |

## Verification
A read accepted at edge T has its first word pair due one sample after edge T+1 and its second pair one sample after edge T+2. The valid flag must fall after edge T+3 unless another read follows. A write commits at the edge after its command, so its data can first be observed by a read accepted at that commit edge. The bench drives inputs and samples outputs on falling edges and counts whole cycles from the command edge to each due sample. Checks for ignored commands look at the memory contents through a later read, or at the valid flag in the cycle an extra burst would have occupied.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
    localparam int BYTE_W_DEF = 9;
    localparam int BYTES_DEF  = 4;
    localparam int ADDR_W_DEF = 4;
    localparam int BURST      = 4;
    localparam int LANES      = 2;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_HEAD = 2'd1,
        OUT_TAIL = 2'd2
    } out_stage_e;

    function automatic logic slot_accept(input logic sel_n, input logic busy);
        return !sel_n && !busy;
    endfunction
endpackage

// File: rtl/qdr4_bank.sv
module qdr4_bank #(
    parameter int ADDR_W = qdr4_pkg::ADDR_W_DEF,
    parameter int BYTE_W = qdr4_pkg::BYTE_W_DEF,
    parameter int BYTES  = qdr4_pkg::BYTES_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [BYTE_W*BYTES-1:0]   wdata,
    input  logic [BYTES-1:0]          wmask_n,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [BYTE_W*BYTES-1:0]   rdata
);
    localparam int DATA_W = BYTE_W * BYTES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (!wmask_n[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qdr4_wr_ctl.sv
module qdr4_wr_ctl #(
    parameter int ADDR_W = qdr4_pkg::ADDR_W_DEF,
    parameter int BYTE_W = qdr4_pkg::BYTE_W_DEF,
    parameter int BYTES  = qdr4_pkg::BYTES_DEF
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          wr_n,
    input  logic [ADDR_W-1:0]                             addr,
    input  logic [BYTE_W*BYTES-1:0]                       din_rise,
    input  logic [BYTE_W*BYTES-1:0]                       din_fall,
    input  logic [BYTES-1:0]                              bw_rise_n,
    input  logic [BYTES-1:0]                              bw_fall_n,
    output logic                                          commit,
    output logic [ADDR_W-1:0]                             waddr,
    output logic [qdr4_pkg::BURST-1:0][BYTE_W*BYTES-1:0]  words,
    output logic [qdr4_pkg::BURST-1:0][BYTES-1:0]         masks_n
);
    import qdr4_pkg::*;
    localparam int DATA_W = BYTE_W * BYTES;

    logic              second;
    logic              accept;
    logic [DATA_W-1:0] head_rise, head_fall;
    logic [BYTES-1:0]  head_rise_m, head_fall_m;

    assign accept = slot_accept(wr_n, second);

    always_ff @(posedge clk) begin
        if (rst) begin
            second      <= 1'b0;
            head_rise   <= '0;
            head_fall   <= '0;
            head_rise_m <= '1;
            head_fall_m <= '1;
        end else begin
            second <= accept;
            if (accept) begin
                head_rise   <= din_rise;
                head_fall   <= din_fall;
                head_rise_m <= bw_rise_n;
                head_fall_m <= bw_fall_n;
            end
        end
    end

    assign commit     = second;
    assign waddr      = addr;
    assign words[0]   = head_rise;
    assign words[1]   = head_fall;
    assign words[2]   = din_rise;
    assign words[3]   = din_fall;
    assign masks_n[0] = head_rise_m;
    assign masks_n[1] = head_fall_m;
    assign masks_n[2] = bw_rise_n;
    assign masks_n[3] = bw_fall_n;
endmodule

// File: rtl/qdr4_rd_ctl.sv
module qdr4_rd_ctl #(
    parameter int ADDR_W = qdr4_pkg::ADDR_W_DEF,
    parameter int DATA_W = qdr4_pkg::BYTE_W_DEF * qdr4_pkg::BYTES_DEF
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    rd_n,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [qdr4_pkg::BURST-1:0][DATA_W-1:0]  rd_words,
    output logic [ADDR_W-1:0]                       raddr,
    output logic [DATA_W-1:0]                       q_rise,
    output logic [DATA_W-1:0]                       q_fall,
    output logic                                    q_valid
);
    import qdr4_pkg::*;

    logic              fetch_pend;
    logic              accept;
    out_stage_e        stage;
    logic [DATA_W-1:0] tail_rise, tail_fall;

    assign accept = slot_accept(rd_n, fetch_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pend <= 1'b0;
            raddr      <= '0;
            stage      <= OUT_IDLE;
            q_rise     <= '0;
            q_fall     <= '0;
            tail_rise  <= '0;
            tail_fall  <= '0;
        end else begin
            fetch_pend <= accept;
            if (accept) raddr <= addr;
            if (fetch_pend) begin
                q_rise    <= rd_words[0];
                q_fall    <= rd_words[1];
                tail_rise <= rd_words[2];
                tail_fall <= rd_words[3];
                stage     <= OUT_HEAD;
            end else if (stage == OUT_HEAD) begin
                q_rise <= tail_rise;
                q_fall <= tail_fall;
                stage  <= OUT_TAIL;
            end else begin
                q_rise <= '0;
                q_fall <= '0;
                stage  <= OUT_IDLE;
            end
        end
    end

    assign q_valid = (stage != OUT_IDLE);
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram #(
    parameter int ADDR_W = qdr4_pkg::ADDR_W_DEF,
    parameter int BYTE_W = qdr4_pkg::BYTE_W_DEF,
    parameter int BYTES  = qdr4_pkg::BYTES_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W*BYTES-1:0]   din_rise,
    input  logic [BYTE_W*BYTES-1:0]   din_fall,
    input  logic [BYTES-1:0]          bw_rise_n,
    input  logic [BYTES-1:0]          bw_fall_n,
    output logic [BYTE_W*BYTES-1:0]   q_rise,
    output logic [BYTE_W*BYTES-1:0]   q_fall,
    output logic                      q_valid
);
    import qdr4_pkg::*;
    localparam int DATA_W = BYTE_W * BYTES;

    logic                             wr_commit;
    logic [ADDR_W-1:0]                waddr, raddr;
    logic [BURST-1:0][DATA_W-1:0]     wr_words, rd_words;
    logic [BURST-1:0][BYTES-1:0]      wr_masks_n;

    qdr4_wr_ctl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_wr (
        .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr),
        .din_rise(din_rise), .din_fall(din_fall),
        .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n),
        .commit(wr_commit), .waddr(waddr), .words(wr_words), .masks_n(wr_masks_n)
    );

    for (genvar k = 0; k < BURST; k++) begin : g_bank
        qdr4_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_bank (
            .clk(clk), .rst(rst), .we(wr_commit), .waddr(waddr),
            .wdata(wr_words[k]), .wmask_n(wr_masks_n[k]),
            .raddr(raddr), .rdata(rd_words[k])
        );
    end

    qdr4_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .rd_n(rd_n), .addr(addr), .rd_words(rd_words),
        .raddr(raddr), .q_rise(q_rise), .q_fall(q_fall), .q_valid(q_valid)
    );
endmodule

// File: rtl/qdr4_chk.sv
module qdr4_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_n,
    input logic              wr_n,
    input logic              wr_commit,
    input logic              q_valid,
    input logic [DATA_W-1:0] q_rise,
    input logic [DATA_W-1:0] q_fall
);
    assert_valid_origin_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> $past(!rd_n, 2));

    assert_valid_two_cycles_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |=> q_valid);

    assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> (q_rise == '0 && q_fall == '0));

    assert_commit_needs_command_R1: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(!wr_n));

    assert_no_back_to_back_commit_R8: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);
endmodule

bind qdr4_sram qdr4_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .wr_commit(wr_commit),
    .q_valid(q_valid), .q_rise(q_rise), .q_fall(q_fall)
);

// File: tb/sim_qdr4_sram.sv
`timescale 1ns/1ps
module sim_qdr4_sram;
    localparam int AW = 4;
    localparam int BW = 9;
    localparam int NB = 4;
    localparam int DW = BW * NB;
    localparam int NV = 6;
    // vector: {addr[3:0], mask16 (word k at bits 4k+3:4k), seed[7:0]}
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,  16'h0000, 8'h11},
        {4'd15, 16'h0000, 8'h5A},
        {4'd5,  16'h0000, 8'h23},
        {4'd5,  16'hA5C3, 8'h77},
        {4'd8,  16'hFFFF, 8'h3C},
        {4'd12, 16'h0000, 8'h90}
    };

    logic clk = 1'b0;
    logic rst;
    logic rd_n, wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din_rise, din_fall, q_rise, q_fall;
    logic [NB-1:0] bw_rise_n, bw_fall_n;
    logic q_valid;
    logic [DW-1:0] mdl [4][1<<AW];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    qdr4_sram u0 (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din_rise(din_rise), .din_fall(din_fall),
        .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n),
        .q_rise(q_rise), .q_fall(q_fall), .q_valid(q_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mkw(input logic [7:0] s, input int k);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++) r[b*BW +: BW] = 9'(s) + 9'(31*k) + 9'(7*b) + 9'd1;
        return r;
    endfunction

    task automatic mdl_update(input logic [AW-1:0] a, input logic [15:0] m, input logic [7:0] s);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < NB; b++)
                if (!m[4*k+b]) mdl[k][a][b*BW +: BW] = mkw(s, k) >> (b*BW);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] m, input logic [7:0] s);
        @(negedge clk);
        wr_n = 1'b0; din_rise = mkw(s, 0); din_fall = mkw(s, 1);
        bw_rise_n = m[3:0]; bw_fall_n = m[7:4];
        @(negedge clk);
        wr_n = 1'b1; addr = a; din_rise = mkw(s, 2); din_fall = mkw(s, 3);
        bw_rise_n = m[11:8]; bw_fall_n = m[15:12];
        mdl_update(a, m, s);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rd_n = 1'b0; wr_n = 1'b1; addr = a;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        chk(q_valid === 1'b1, {tag, " valid head"}, DW'(q_valid), DW'(1));
        chk(q_rise === mdl[0][a], {tag, " word0"}, q_rise, mdl[0][a]);
        chk(q_fall === mdl[1][a], {tag, " word1"}, q_fall, mdl[1][a]);
        @(negedge clk);
        chk(q_valid === 1'b1, {tag, " valid tail"}, DW'(q_valid), DW'(1));
        chk(q_rise === mdl[2][a], {tag, " word2"}, q_rise, mdl[2][a]);
        chk(q_fall === mdl[3][a], {tag, " word3"}, q_fall, mdl[3][a]);
        @(negedge clk);
        chk(q_valid === 1'b0, {tag, " valid drop"}, DW'(q_valid), DW'(0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < (1<<AW); i++) mdl[k][i] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] old [4];
        rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0;
        din_rise = '0; din_fall = '0; bw_rise_n = '1; bw_fall_n = '1;
        do_reset();

        // R10: reset state
        chk(q_valid === 1'b0, "R10 valid after reset", DW'(q_valid), DW'(0));
        chk(q_rise === '0, "R10 q_rise after reset", q_rise, '0);
        do_read(4'd9, "R10 cleared memory");

        // R4 R5 R6: table of write/read vectors
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][27:24], VEC[v][23:8], VEC[v][7:0]);
            do_read(VEC[v][27:24], "R4 R5 R6 vector");
        end

        // R1: deselected write port leaves memory unchanged
        @(negedge clk);
        wr_n = 1'b1; addr = 4'd15; din_rise = '1; din_fall = '1; bw_rise_n = '0; bw_fall_n = '0;
        @(negedge clk);
        din_rise = 36'h123456789; din_fall = 36'h0ABCDEF01;
        do_read(4'd15, "R1 ignored data");

        // R8: write command in second cycle is ignored
        @(negedge clk);
        wr_n = 1'b0; din_rise = mkw(8'h40, 0); din_fall = mkw(8'h40, 1); bw_rise_n = '0; bw_fall_n = '0;
        @(negedge clk);
        wr_n = 1'b0; addr = 4'd6; din_rise = mkw(8'h40, 2); din_fall = mkw(8'h40, 3);
        @(negedge clk);
        wr_n = 1'b1; addr = 4'd7; din_rise = '1; din_fall = '1;
        mdl_update(4'd6, 16'h0000, 8'h40);
        do_read(4'd6, "R8 accepted write");
        do_read(4'd7, "R8 ignored write");

        // R8 R2: read command in second cycle is ignored
        @(negedge clk);
        rd_n = 1'b0; addr = 4'd0;
        @(negedge clk);
        rd_n = 1'b0; addr = 4'd15;
        @(negedge clk);
        rd_n = 1'b1;
        chk(q_rise === mdl[0][0], "R2 addr at command edge", q_rise, mdl[0][0]);
        @(negedge clk);
        chk(q_fall === mdl[3][0], "R2 tail word", q_fall, mdl[3][0]);
        @(negedge clk);
        chk(q_valid === 1'b0, "R8 no extra read burst", DW'(q_valid), DW'(0));

        // R9 R3: reads every two cycles, continuous valid
        @(negedge clk);
        rd_n = 1'b0; addr = 4'd0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0; addr = 4'd5;
        chk(q_valid === 1'b1 && q_rise === mdl[0][0], "R3 first burst head", q_rise, mdl[0][0]);
        @(negedge clk);
        rd_n = 1'b1;
        chk(q_valid === 1'b1 && q_fall === mdl[3][0], "R3 first burst tail", q_fall, mdl[3][0]);
        @(negedge clk);
        chk(q_valid === 1'b1 && q_fall === mdl[1][5], "R9 gapless second head", q_fall, mdl[1][5]);
        @(negedge clk);
        chk(q_valid === 1'b1 && q_rise === mdl[2][5], "R9 gapless second tail", q_rise, mdl[2][5]);
        @(negedge clk);
        chk(q_valid === 1'b0, "R9 valid low after bursts", DW'(q_valid), DW'(0));
        chk(q_rise === '0 && q_fall === '0, "R9 idle outputs zero", q_rise | q_fall, '0);

        // R7: read and write accepted at the same edge, same address
        for (int k = 0; k < 4; k++) old[k] = mdl[k][12];
        @(negedge clk);
        rd_n = 1'b0; wr_n = 1'b0; addr = 4'd12;
        din_rise = mkw(8'hC1, 0); din_fall = mkw(8'hC1, 1); bw_rise_n = '0; bw_fall_n = '0;
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; addr = 4'd12; din_rise = mkw(8'hC1, 2); din_fall = mkw(8'hC1, 3);
        @(negedge clk);
        chk(q_rise === old[0] && q_fall === old[1], "R7 old head", q_rise, old[0]);
        @(negedge clk);
        chk(q_rise === old[2] && q_fall === old[3], "R7 old tail", q_fall, old[3]);
        mdl_update(4'd12, 16'h0000, 8'hC1);
        do_read(4'd12, "R7 new data after");

        // R11: read in the write's address cycle shares the bus value
        @(negedge clk);
        wr_n = 1'b0; din_rise = mkw(8'h2E, 0); din_fall = mkw(8'h2E, 1); bw_rise_n = '0; bw_fall_n = '0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0; addr = 4'd13; din_rise = mkw(8'h2E, 2); din_fall = mkw(8'h2E, 3);
        mdl_update(4'd13, 16'h0000, 8'h2E);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        chk(q_valid === 1'b1 && q_rise === mdl[0][13], "R11 shared addr head", q_rise, mdl[0][13]);
        @(negedge clk);
        chk(q_fall === mdl[3][13], "R11 shared addr tail", q_fall, mdl[3][13]);

        // R10: reset after writes clears memory
        do_reset();
        do_read(4'd13, "R10 cleared after reuse");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule